// File: doc/BRIEF.md
# Two-Tier Stream Priority Arbiter

This block decides which of eight transfer streams may use a shared transfer engine. Each stream draws its request from one of eight peripheral channel lines. A per-stream select field picks the line, and a per-stream enable gates it. The streams that are enabled and whose selected line is high are eligible.

The arbiter picks the eligible stream with the highest programmed two-bit level. When several streams share that level, the lowest stream index wins. The winner is registered and presented as a one-hot grant, an encoded index and a valid flag.

A grant stays in place until the engine raises `done` at the end of the winner's burst or single beat. Only then is arbitration repeated, so an ownership change never happens in the middle of a burst.

Top module: `strm_prio_arb`

## Requirements
- R1: While reset is asserted and after reset is released with no eligible stream, `grant` is all zeros, `grant_vld` is low and `grant_idx` is 0.
- R2: Stream s requests only when bit `s*8 + sel` of `chan_req` is high, where `sel` is the 3-bit field `chan_sel[3*s +: 3]`. A high line on any other channel of that stream has no effect.
- R3: A stream whose `strm_en[s]` bit is low is never given a new grant, whatever its selected channel line shows.
- R4: Among eligible streams, the one with the highest level wins. The level of stream s is `prio_lvl[2*s +: 2]`, read as 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low.
- R5: When several eligible streams share the highest level, the one with the lowest index wins.
- R6: Once `grant_vld` is high, the grant holds unchanged until a clock edge at which `done` is high. At that edge a new winner is chosen from the inputs present at that edge.
- R7: When arbitration finds no eligible stream, the next grant is all zeros and `grant_vld` is low.
- R8: `grant` has at most one bit set. When `grant_vld` is high, that bit is bit `grant_idx`. The new grant appears one clock edge after the inputs that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 64 | Peripheral channel lines; bit s*8+c is channel c of stream s |
| chan_sel | input | 24 | Channel select; 3 bits per stream, stream s at [3s+:3] |
| prio_lvl | input | 16 | Priority level; 2 bits per stream, stream s at [2s+:2] |
| strm_en | input | 8 | Per-stream enable |
| done | input | 1 | End of the granted stream's burst or single beat |
| grant | output | 8 | One-hot grant |
| grant_idx | output | 3 | Encoded index of the granted stream |
| grant_vld | output | 1 | A grant is active |

## Verification
The bench sets a request on a channel line that is not selected and expects no grant. A design that muxes the wrong bit would grant that stream anyway.

It sets up three-way contests at different levels, and then tie contests where a lower-level stream with a lower index is also active. A design that compared only by index, or that let a later stream with an equal level replace an earlier one, would name the wrong winner.

It raises a higher-level request while a low-level grant is held. A design that re-arbitrates every cycle would hand over the grant early, before `done`. It also checks that disabled requesters are passed over, and that dropping every request empties the grant.

// File: rtl/strm_prio_arb.sv
module strm_prio_arb #(
  parameter int NSTRM = 8,
  parameter int NCHAN = 8,
  parameter int PW    = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NSTRM*NCHAN-1:0]          chan_req,
  input  logic [NSTRM*$clog2(NCHAN)-1:0]  chan_sel,
  input  logic [NSTRM*PW-1:0]             prio_lvl,
  input  logic [NSTRM-1:0]                strm_en,
  input  logic                            done,
  output logic [NSTRM-1:0]                grant,
  output logic [$clog2(NSTRM)-1:0]        grant_idx,
  output logic                            grant_vld
);
  localparam int SW = $clog2(NSTRM);
  localparam int CW = $clog2(NCHAN);

  logic [NSTRM-1:0] elig;
  logic             win_vld;
  logic [SW-1:0]    win_idx;
  logic [PW-1:0]    best;
  logic             vld_q;
  logic [SW-1:0]    idx_q;

  for (genvar s = 0; s < NSTRM; s++) begin : g_elig
    assign elig[s] = strm_en[s] & chan_req[s*NCHAN + int'(chan_sel[s*CW +: CW])];
  end

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int s = 0; s < NSTRM; s++) begin
      if (elig[s] && (!win_vld || prio_lvl[s*PW +: PW] > best)) begin
        win_vld = 1'b1;
        win_idx = SW'(s);
        best    = prio_lvl[s*PW +: PW];
      end
    end
  end

  wire rearb = !vld_q || done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (rearb) begin
      vld_q <= win_vld;
      idx_q <= win_idx;
    end
  end

  assign grant_vld = vld_q;
  assign grant_idx = idx_q;
  assign grant     = vld_q ? (NSTRM'(1) << idx_q) : '0;
endmodule

module strm_prio_arb_chk #(
  parameter int NSTRM = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NSTRM-1:0]         strm_en,
  input logic                     done,
  input logic [NSTRM-1:0]         grant,
  input logic [$clog2(NSTRM)-1:0] grant_idx,
  input logic                     grant_vld
);
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r8_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> grant[grant_idx]);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !done) |=> (grant_vld && $stable(grant) && $stable(grant_idx)));

  a_r3_no_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld || done) |=> ((grant & ~$past(strm_en)) == '0));
endmodule

bind strm_prio_arb strm_prio_arb_chk #(.NSTRM(NSTRM)) u_chk (
  .clk(clk), .rst_n(rst_n), .strm_en(strm_en), .done(done),
  .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld));

// File: tb/strm_prio_arb_bench.sv
`timescale 1ns/1ps
module strm_prio_arb_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] chan_req = '0;
  logic [23:0] chan_sel = '0;
  logic [15:0] prio_lvl = '0;
  logic [7:0]  strm_en = '1;
  logic        done = 0;
  logic [7:0]  grant;
  logic [2:0]  grant_idx;
  logic        grant_vld;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  strm_prio_arb u_strm_prio_arb (.*);

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, bit ev, int ei);
    logic [7:0] eg;
    eg = ev ? 8'(1 << ei) : 8'h00;
    checks++;
    if (grant_vld !== ev || grant !== eg || (ev && grant_idx !== 3'(ei))) begin
      errors++;
      $display("FAIL %s: vld=%b grant=%b idx=%0d expected vld=%b grant=%b idx=%0d",
               tag, grant_vld, grant, grant_idx, ev, eg, ei);
    end
  endtask

  task automatic req(int s, int lvl, bit on);
    prio_lvl[2*s +: 2] = 2'(lvl);
    chan_req[s*8 + int'(chan_sel[3*s +: 3])] = on;
  endtask

  task automatic clear();
    chan_req = '0; chan_sel = '0; prio_lvl = '0; strm_en = '1;
    done = 1; cyc(); done = 0;
    chk("R7 empty after clear", 0, 0);
  endtask

  task automatic pulse_done();
    done = 1; cyc(); done = 0;
  endtask

  task automatic t_reset();
    chk("R1 in reset", 0, 0);
    rst_n = 1; cyc(); cyc();
    chk("R1 after reset idle", 0, 0);
  endtask

  task automatic t_select();
    chan_sel[3*2 +: 3] = 3'd5;
    chan_req[2*8 + 3] = 1; cyc();
    chk("R2 unselected channel ignored", 0, 0);
    chan_req[2*8 + 5] = 1; cyc();
    chk("R2 selected channel grants", 1, 2);
    clear();
  endtask

  task automatic t_prio();
    req(1, 1, 1); req(4, 3, 1); req(6, 2, 1); cyc();
    chk("R4 very high wins", 1, 4);
    req(4, 3, 0); pulse_done();
    chk("R4 high next", 1, 6);
    req(6, 2, 0); pulse_done();
    chk("R4 medium last", 1, 1);
    clear();
  endtask

  task automatic t_tie();
    req(0, 1, 1); req(3, 2, 1); req(5, 2, 1); req(7, 2, 1); cyc();
    chk("R5 lowest index among equals", 1, 3);
    req(3, 2, 0); pulse_done();
    chk("R5 next lowest index", 1, 5);
    req(5, 2, 0); req(7, 2, 0); pulse_done();
    chk("R4 lower level after ties", 1, 0);
    clear();
  endtask

  task automatic t_disable();
    strm_en[0] = 0;
    req(0, 3, 1); req(7, 0, 1); cyc();
    chk("R3 disabled stream skipped", 1, 7);
    strm_en = '0; pulse_done();
    chk("R3 all disabled no grant", 0, 0);
    clear();
  endtask

  task automatic t_hold();
    req(5, 0, 1); cyc();
    chk("R6 low stream granted", 1, 5);
    req(2, 3, 1); cyc();
    chk("R6 held despite higher request", 1, 5);
    cyc(); cyc();
    chk("R6 still held", 1, 5);
    pulse_done();
    chk("R6 re-arbitrate on done", 1, 2);
    req(2, 3, 0); req(5, 0, 0); cyc();
    chk("R6 held after requests drop", 1, 2);
    pulse_done();
    chk("R7 nothing eligible", 0, 0);
    clear();
  endtask

  initial begin
    t_reset();
    t_select();
    t_prio();
    t_tie();
    t_disable();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule